// File: doc/BRIEF.md
# Binary-Tree Anticollision Identifier Serializer

This block is the tag-side part of a bit-by-bit binary-tree anticollision round. The tag identifier is held across three 32-bit words and aligned to the most significant bit. Its length is configurable from 16 to 96 bits in steps of 8 and is 64 bits after reset. Once a round starts, the block offers one identifier bit per slot, beginning with bit 31 of word 0 and moving down toward bit 0 of word 2. The reader strobes each slot together with the bit value it has chosen for that slot.

While every chosen bit equals the tag's own bit, the tag stays active and moves on to the next slot. On the first difference it leaves the round and stays silent until the next round start. If the slot at the configured length matches, the tag is singled out and raises its selected flag, which then holds. Every tag in the field runs the same walk in parallel, so the reader isolates one tag by steering down the tree. Radio modulation and command decoding sit outside this block.

Top module: `bintree_id_serializer`

## Requirements
- R1: After reset, active is 0, selected is 0, tx_bit is 0, and the identifier length is 64 bits.
- R2: A round_start pulse makes active 1, selected 0 and the slot index 0 on the next cycle. It takes priority over a bit_strobe in the same cycle.
- R3: While active, tx_bit carries the identifier bit of the current slot k: word k/32, bit 31-(k mod 32). Word 0 sits in id_words[95:64], word 1 in [63:32] and word 2 in [31:0], so slot 0 is id_words[95].
- R4: A bit_strobe whose reader_bit equals tx_bit, on a slot before the last one, moves the tag to the next slot on the next cycle and keeps it active.
- R5: A bit_strobe whose reader_bit differs from tx_bit clears active on the next cycle. tx_bit then stays 0 and active stays 0 until the next round_start.
- R6: A matching bit_strobe on the last slot (length-1) sets selected and clears active on the next cycle. selected stays 1 until the next round_start.
- R7: A cycle with cfg_len_we high loads cfg_len as the new length. The value is first rounded down to a multiple of 8 and then clamped into 16..96, so 8 gives 16, 44 gives 40 and 120 gives 96.
- R8: A bit_strobe while active is 0, either before any round or after the tag has dropped out or been selected, changes neither active, selected nor tx_bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| round_start | input | 1 | One-cycle pulse that opens a new anticollision round |
| bit_strobe | input | 1 | One-cycle pulse marking the end of a slot |
| reader_bit | input | 1 | Bit value the reader chose for the slot, valid with bit_strobe |
| cfg_len_we | input | 1 | Loads cfg_len into the length register |
| cfg_len | input | 7 | Requested identifier length in bits |
| id_words | input | 96 | The three identifier words, word 0 in the top bits |
| tx_bit | output | 1 | Identifier bit for the current slot, 0 when not active |
| active | output | 1 | Tag is still taking part in the round |
| selected | output | 1 | Tag matched every bit up to the configured length |

## Verification
Every registered result appears one clock edge after the input that causes it. A round_start, a bit_strobe or a length write presented before a rising edge shows up in active, selected and the slot index right after that edge. tx_bit follows the registered slot index combinationally, so it is valid in the same sampling window. The bench drives inputs on the falling edge, keeps each pulse for exactly one rising edge, and reads the outputs at the next falling edge. The length setting is checked by counting strobes: the tag must still be active and unselected after length-1 matching strobes and selected after the next one.

// File: rtl/bts_pkg.sv
// Package for the anticollision serializer: holds the walk state encoding
// that the controller and the top module share.
package bts_pkg;

    // Walk state of one tag within a round
    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,   // no round since reset
        WALK_RUN  = 2'd1,   // matching so far, still transmitting
        WALK_OUT  = 2'd2,   // dropped out on a mismatch
        WALK_SEL  = 2'd3    // every configured bit matched
    } walk_state_t;

endpackage

// File: rtl/bts_len_cfg.sv
// Length register for the identifier. A write is rounded down to a whole
// step and then clamped into [MIN_LEN, MAX_LEN]. Reset loads DEF_LEN.
// Assumes DEF_LEN is already legal and MAX_LEN fits in LEN_W bits.
module bts_len_cfg #(
    parameter int LEN_W   = 7,
    parameter int MIN_LEN = 16,
    parameter int MAX_LEN = 96,
    parameter int STEP    = 8,
    parameter int DEF_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] len_q
);

    logic [LEN_W-1:0] rounded;
    logic [LEN_W-1:0] legal;

    // Round the request down to a step multiple, then clamp it
    always_comb begin
        rounded = wr_len - (wr_len % LEN_W'(STEP));
        if (rounded < LEN_W'(MIN_LEN))
            legal = LEN_W'(MIN_LEN);
        else if (rounded > LEN_W'(MAX_LEN))
            legal = LEN_W'(MAX_LEN);
        else
            legal = rounded;
    end

    // Hold the length; reset restores the default
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= LEN_W'(DEF_LEN);
        else if (wr_en)
            len_q <= legal;
    end

endmodule

// File: rtl/bts_bit_pick.sv
// Picks the identifier bit for a slot. Slot 0 is the top bit of the
// flattened word vector and slots count downward. Assumes word 0 sits in
// the most significant bits. Slots past the end read as 0.
module bts_bit_pick #(
    parameter int TOTAL = 96,
    parameter int IDX_W = 7
) (
    input  logic [TOTAL-1:0] id_words,
    input  logic [IDX_W-1:0] slot_idx,
    output logic             slot_bit
);

    logic [TOTAL-1:0] stream;

    // Reverse the vector so that slot k reads stream[k]
    for (genvar g = 0; g < TOTAL; g++) begin : g_rev
        assign stream[g] = id_words[TOTAL-1-g];
    end

    // Select the slot bit, guarding indices past the end
    always_comb begin
        if (int'(slot_idx) < TOTAL)
            slot_bit = stream[slot_idx];
        else
            slot_bit = 1'b0;
    end

endmodule

// File: rtl/bts_walk_ctrl.sv
// Walk controller for one anticollision round. It keeps the slot index and
// the walk state, compares the reader's bit with the tag's bit on each
// strobe, and ends the walk on a mismatch or after the last slot.
// Assumes len_q is in 1..2**IDX_W.
module bts_walk_ctrl
    import bts_pkg::*;
#(
    parameter int LEN_W = 7,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             round_start,
    input  logic             bit_strobe,
    input  logic             reader_bit,
    input  logic             cur_bit,
    input  logic [LEN_W-1:0] len_q,
    output logic [IDX_W-1:0] slot_idx,
    output walk_state_t      state
);

    logic last_slot;

    // Flag the slot that ends the configured identifier
    always_comb last_slot = (LEN_W'(slot_idx) == (len_q - LEN_W'(1)));

    // Advance the walk; a round start overrides everything else
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WALK_IDLE;
            slot_idx <= '0;
        end else if (round_start) begin
            state    <= WALK_RUN;
            slot_idx <= '0;
        end else if (bit_strobe && state == WALK_RUN) begin
            if (reader_bit != cur_bit)
                state <= WALK_OUT;
            else if (last_slot)
                state <= WALK_SEL;
            else
                slot_idx <= slot_idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/bintree_id_serializer.sv
// Top of the tag-side binary-tree anticollision serializer. It ties the
// length register, the slot bit picker and the walk controller together,
// and gates the transmit bit with the active state.
// Assumes round_start and bit_strobe are one-cycle pulses synchronous to clk.
module bintree_id_serializer
    import bts_pkg::*;
#(
    parameter  int WORD_W    = 32,
    parameter  int NUM_WORDS = 3,
    parameter  int LEN_STEP  = 8,
    parameter  int MIN_LEN   = 16,
    parameter  int DEF_LEN   = 64,
    localparam int ID_W      = WORD_W * NUM_WORDS,
    localparam int MAX_LEN   = ID_W,
    localparam int IDX_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             round_start,
    input  logic             bit_strobe,
    input  logic             reader_bit,
    input  logic             cfg_len_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [ID_W-1:0]  id_words,
    output logic             tx_bit,
    output logic             active,
    output logic             selected
);

    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] slot_idx;
    logic             cur_bit;
    walk_state_t      state;

    bts_len_cfg #(
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN),
        .STEP   (LEN_STEP),
        .DEF_LEN(DEF_LEN)
    ) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_len_we),
        .wr_len(cfg_len),
        .len_q (len_q)
    );

    bts_bit_pick #(
        .TOTAL(ID_W),
        .IDX_W(IDX_W)
    ) u_pick (
        .id_words(id_words),
        .slot_idx(slot_idx),
        .slot_bit(cur_bit)
    );

    bts_walk_ctrl #(
        .LEN_W(LEN_W),
        .IDX_W(IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .round_start(round_start),
        .bit_strobe (bit_strobe),
        .reader_bit (reader_bit),
        .cur_bit    (cur_bit),
        .len_q      (len_q),
        .slot_idx   (slot_idx),
        .state      (state)
    );

    // Decode the outputs; the tag is silent unless still walking
    always_comb begin
        active   = (state == WALK_RUN);
        selected = (state == WALK_SEL);
        tx_bit   = active & cur_bit;
    end

endmodule

// File: rtl/bts_checker.sv
// Assertion checker for the anticollision serializer, bound to the top.
// It watches the ports plus the slot index and the length register.
module bts_checker #(
    parameter int LEN_W   = 7,
    parameter int IDX_W   = 7,
    parameter int MIN_LEN = 16,
    parameter int MAX_LEN = 96,
    parameter int STEP    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             round_start,
    input logic             bit_strobe,
    input logic             reader_bit,
    input logic             tx_bit,
    input logic             active,
    input logic             selected,
    input logic [IDX_W-1:0] slot_idx,
    input logic [LEN_W-1:0] len_q
);

    // R2
    round_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_start |=> (active && !selected && slot_idx == '0));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_strobe && !round_start && reader_bit == tx_bit)
        |=> ((active && slot_idx == $past(slot_idx) + IDX_W'(1)) || selected));

    // R5
    mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_strobe && !round_start && reader_bit != tx_bit)
        |=> (!active && !selected && !tx_bit));

    // R5
    stay_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !round_start) |=> !active);

    // R5
    silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !tx_bit);

    // R6
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !round_start) |=> selected);

    // R6
    sel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> $past(active && bit_strobe && reader_bit == tx_bit));

    // R6
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && selected));

    // R7
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LEN_W'(MIN_LEN) && len_q <= LEN_W'(MAX_LEN)
         && (len_q % LEN_W'(STEP)) == '0));

endmodule

bind bintree_id_serializer bts_checker #(
    .LEN_W  (LEN_W),
    .IDX_W  (IDX_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN),
    .STEP   (LEN_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .round_start(round_start),
    .bit_strobe (bit_strobe),
    .reader_bit (reader_bit),
    .tx_bit     (tx_bit),
    .active     (active),
    .selected   (selected),
    .slot_idx   (slot_idx),
    .len_q      (len_q)
);

// File: tb/bintree_id_serializer_test.sv
// Directed bench for the anticollision serializer: one task per scenario.
module bintree_id_serializer_test;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        round_start = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        reader_bit = 1'b0;
    logic        cfg_len_we = 1'b0;
    logic [6:0]  cfg_len = '0;
    logic [ID_W-1:0] id_words = {32'hA5C3_0F96, 32'h3C69_E1D2, 32'h7B18_4E2D};
    logic        tx_bit;
    logic        active;
    logic        selected;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bintree_id_serializer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .round_start(round_start),
        .bit_strobe (bit_strobe),
        .reader_bit (reader_bit),
        .cfg_len_we (cfg_len_we),
        .cfg_len    (cfg_len),
        .id_words   (id_words),
        .tx_bit     (tx_bit),
        .active     (active),
        .selected   (selected)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_bit(input int k);
        return id_words[ID_W-1-k];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic ea, input logic es, input logic et);
        check(active == ea, {req, " active"}, int'(active), int'(ea));
        check(selected == es, {req, " selected"}, int'(selected), int'(es));
        check(tx_bit == et, {req, " tx_bit"}, int'(tx_bit), int'(et));
    endtask

    task automatic pulse_start();
        round_start = 1'b1;
        @(negedge clk);
        round_start = 1'b0;
    endtask

    task automatic strobe(input logic b);
        bit_strobe = 1'b1;
        reader_bit = b;
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic write_len(input int v);
        cfg_len_we = 1'b1;
        cfg_len = 7'(v);
        @(negedge clk);
        cfg_len_we = 1'b0;
    endtask

    // R3 R4 R6: full matching walk over len slots
    task automatic walk_match(input int len, input string tag);
        pulse_start();
        for (int k = 0; k < len; k++) begin
            if (!active || selected || tx_bit != exp_bit(k))
                check_out({tag, " R3 R4 slot"}, 1'b1, 1'b0, exp_bit(k));
            else
                check(1'b1, "R3", 0, 0);
            strobe(exp_bit(k));
        end
        check_out({tag, " R6 final"}, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check_out("R1 reset", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_idle_strobe();
        strobe(1'b1);
        strobe(1'b0);
        check_out("R8 idle strobe", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_default_len();
        walk_match(64, "R1 default64");
    endtask

    task automatic t_sel_hold();
        strobe(1'b0);
        strobe(1'b1);
        check_out("R6 R8 held selected", 1'b0, 1'b1, 1'b0);
        pulse_start();
        check_out("R2 restart clears selected", 1'b1, 1'b0, exp_bit(0));
    endtask

    task automatic t_mismatch();
        pulse_start();
        for (int k = 0; k < 5; k++) strobe(exp_bit(k));
        check_out("R4 slot5 reached", 1'b1, 1'b0, exp_bit(5));
        strobe(~exp_bit(5));
        check_out("R5 mismatch drop", 1'b0, 1'b0, 1'b0);
        strobe(exp_bit(6));
        strobe(~exp_bit(6));
        strobe(1'b1);
        check_out("R5 R8 stays out", 1'b0, 1'b0, 1'b0);
        pulse_start();
        check_out("R2 rejoin slot0", 1'b1, 1'b0, exp_bit(0));
        strobe(exp_bit(0));
        check_out("R2 R4 slot1 after restart", 1'b1, 1'b0, exp_bit(1));
    endtask

    task automatic t_priority();
        pulse_start();
        for (int k = 0; k < 3; k++) strobe(exp_bit(k));
        round_start = 1'b1;
        bit_strobe = 1'b1;
        reader_bit = ~exp_bit(3);
        @(negedge clk);
        round_start = 1'b0;
        bit_strobe = 1'b0;
        check_out("R2 start beats strobe", 1'b1, 1'b0, exp_bit(0));
    endtask

    // R7: length takes effect, probed by strobe count
    task automatic t_len(input int req, input int eff);
        write_len(req);
        walk_match(eff, $sformatf("R7 len %0d->%0d", req, eff));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_strobe();
        t_default_len();
        t_sel_hold();
        t_mismatch();
        t_priority();
        t_len(16, 16);
        t_len(96, 96);
        t_len(8, 16);
        t_len(120, 96);
        t_len(44, 40);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule